// File: doc/BRIEF.md
# Keyed Low-Speed Clock Selector

This block picks the source of the slow timekeeping tick for an always-on domain. One source is an internal RC oscillator. It is first divided by a fixed stage, then by a programmable prescaler. The other source is an external 32 kHz crystal. Both sources reach the block as single-cycle enable pulses synchronous to the system clock. The chosen source leaves the block as an enable-style tick, `slow_tick`. A gated copy, `pin_tick`, can drive an output pin.

Software controls the block through a small register port with three registers:

- **Mode register (0x00).** A write lands only if the upper half-word holds the unlock key `0x16AA`. It holds the source request (bit 0), the crystal enable (bit 4) and the fallback bypass (bit 15).
- **Divider register (0x08).** Holds the prescaler value N in bits 4:0.
- **Pin register (0x60).** Bit 0 gates the tick out to the pin.

A source change is hitless. When the request changes, the output falls silent. It stays silent until the new source has produced two ticks, and only then is the selection committed. When the crystal reports a failure, the block falls back to the internal path unless the bypass bit is set.

Top module: `slowclk_sel`

## Requirements
- R1: After reset the mode, divider and pin registers read 0, the internal source is selected, `ext_osc_en` is 0 and no tick is emitted.
- R2: A write to offset 0x00 updates bits 0, 4 and 15 only when `reg_wdata[31:16]` equals 0x16AA. With any other key value the write is ignored and the readback is unchanged.
- R3: With the internal source selected, `slow_tick` pulses once for every 32×(N+1) pulses on `int_osc_tick`, with N taken from bits 4:0 at offset 0x08. Counting starts from reset.
- R4: With the external source selected and mode bit 4 set, each `ext_osc_tick` pulse yields exactly one `slow_tick` pulse, one cycle later.
- R5: After the requested source changes, `slow_tick` stays low until the new source has ticked twice. Readback bit 0 changes to the new source at the second tick. Every later tick of the new source passes through.
- R6: While mode bit 4 is 0, `ext_osc_tick` pulses are ignored. A switch to the external source then stays pending: readback bit 0 stays 0 and no tick is emitted.
- R7: While `ext_fail` is high and mode bit 15 is 0, the block moves to the internal source through the R5 handshake. With bit 15 set, the external source is kept.
- R8: `pin_tick` equals `slow_tick` while bit 0 of offset 0x60 is 1, and is 0 otherwise.
- R9: Readbacks are as follows. Offset 0x00 returns the current source in bit 0, the written values of bits 4 and 15, and zeros elsewhere, including the key field. Offset 0x08 returns N in bits 4:0. Offset 0x60 returns the gate in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| int_osc_tick | input | 1 | Internal RC oscillator pulse |
| ext_osc_tick | input | 1 | External crystal pulse |
| ext_fail | input | 1 | Crystal failure indication, level |
| ext_osc_en | output | 1 | Crystal enable (mode bit 4) |
| slow_tick | output | 1 | Selected slow tick |
| pin_tick | output | 1 | Gated tick for the output pin |

## Verification
Register writes take effect at the sampling edge, and `reg_rdata` is combinational. The bench therefore reads back one cycle after a write.

Timing of the two tick paths:

- **External path.** A crystal pulse reaches `slow_tick` after one register.
- **Internal path.** A pulse crosses the divider register and then the output register, so it arrives two edges after the last counted pulse.

Every tick-count check waits several idle cycles after its last stimulus before it reads counters. These counters sample the outputs on the falling edge. Handshake checks read bit 0 between the first and second new-source pulses, and again after the second.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'h16AA;
  localparam int OFS_MODE = 8'h00;
  localparam int OFS_DIV  = 8'h08;
  localparam int OFS_PIN  = 8'h60;
  localparam int BIT_SEL    = 0;
  localparam int BIT_XEN    = 4;
  localparam int BIT_BYPASS = 15;

  typedef struct packed {
    logic bypass;
    logic xtal_en;
    logic src_req;
  } mode_t;
endpackage

// File: rtl/slowclk_regs.sv
module slowclk_regs
  import slowclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cur_ext,
  output logic [DATA_W-1:0] rdata,
  output mode_t             mode,
  output logic [PRE_W-1:0]  pre_n,
  output logic              pin_en
);
  localparam int KEY_LSB = DATA_W - 16;

  mode_t            mode_d;
  logic [PRE_W-1:0] pre_d;
  logic             pin_d;
  logic             key_ok;
  logic             hit_mode, hit_div, hit_pin;
  logic             unused_wdata;

  assign key_ok   = (wdata[DATA_W-1:KEY_LSB] == UNLOCK_KEY);
  assign hit_mode = wr && (addr == ADDR_W'(OFS_MODE));
  assign hit_div  = wr && (addr == ADDR_W'(OFS_DIV));
  assign hit_pin  = wr && (addr == ADDR_W'(OFS_PIN));
  assign unused_wdata = ^wdata;

  always_comb begin
    mode_d = mode;
    pre_d  = pre_n;
    pin_d  = pin_en;
    if (hit_mode && key_ok) begin
      mode_d.src_req = wdata[BIT_SEL];
      mode_d.xtal_en = wdata[BIT_XEN];
      mode_d.bypass  = wdata[BIT_BYPASS];
    end
    if (hit_div) pre_d = wdata[PRE_W-1:0];
    if (hit_pin) pin_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= '0;
      pre_n  <= '0;
      pin_en <= 1'b0;
    end else begin
      mode   <= mode_d;
      pre_n  <= pre_d;
      pin_en <= pin_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(OFS_MODE): begin
        rdata[BIT_SEL]    = cur_ext;
        rdata[BIT_XEN]    = mode.xtal_en;
        rdata[BIT_BYPASS] = mode.bypass;
      end
      ADDR_W'(OFS_DIV): rdata[PRE_W-1:0] = pre_n;
      ADDR_W'(OFS_PIN): rdata[0] = pin_en;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/slowclk_div.sv
module slowclk_div #(
  parameter int FIX_DIV = 32,
  parameter int PRE_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_tick,
  input  logic [PRE_W-1:0] pre_n,
  output logic             out_tick
);
  logic fix_fire;

  generate
    if (FIX_DIV > 1) begin : g_fixed
      localparam int FW = $clog2(FIX_DIV);
      logic [FW-1:0] fcnt_q, fcnt_d;
      logic          at_end;
      assign at_end   = (fcnt_q == FW'(FIX_DIV - 1));
      assign fix_fire = in_tick && at_end;
      always_comb begin
        fcnt_d = fcnt_q;
        if (in_tick) fcnt_d = at_end ? '0 : fcnt_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fcnt_q <= '0;
        else        fcnt_q <= fcnt_d;
      end
    end else begin : g_nofixed
      assign fix_fire = in_tick;
    end
  endgenerate

  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic             wrap, fire, out_d;

  assign wrap = (pcnt_q >= pre_n);
  assign fire = fix_fire && wrap;

  always_comb begin
    pcnt_d = pcnt_q;
    if (fix_fire) pcnt_d = wrap ? '0 : pcnt_q + 1'b1;
    out_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q   <= '0;
      out_tick <= 1'b0;
    end else begin
      pcnt_q   <= pcnt_d;
      out_tick <= out_d;
    end
  end
endmodule

// File: rtl/slowclk_switch.sv
module slowclk_switch #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_ext,
  input  logic int_t,
  input  logic ext_t,
  output logic cur_ext,
  output logic pending,
  output logic tick
);
  localparam int SW = $clog2(SETTLE + 1);

  logic          cur_d, pend_d, tick_d, new_t;
  logic [SW-1:0] seen_q, seen_d;

  assign new_t = want_ext ? ext_t : int_t;

  always_comb begin
    cur_d  = cur_ext;
    pend_d = pending;
    seen_d = seen_q;
    if (!pending) begin
      seen_d = '0;
      if (want_ext != cur_ext) pend_d = 1'b1;
    end else if (want_ext == cur_ext) begin
      pend_d = 1'b0;
      seen_d = '0;
    end else if (new_t) begin
      if (seen_q == SW'(SETTLE - 1)) begin
        cur_d  = want_ext;
        pend_d = 1'b0;
        seen_d = '0;
      end else begin
        seen_d = seen_q + 1'b1;
      end
    end
    tick_d = !pending && (cur_ext ? ext_t : int_t);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_ext <= 1'b0;
      pending <= 1'b0;
      seen_q  <= '0;
      tick    <= 1'b0;
    end else begin
      cur_ext <= cur_d;
      pending <= pend_d;
      seen_q  <= seen_d;
      tick    <= tick_d;
    end
  end
endmodule

// File: rtl/slowclk_sel.sv
module slowclk_sel
  import slowclk_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int PRE_W   = 5,
  parameter int FIX_DIV = 32,
  parameter int SETTLE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              int_osc_tick,
  input  logic              ext_osc_tick,
  input  logic              ext_fail,
  output logic              ext_osc_en,
  output logic              slow_tick,
  output logic              pin_tick
);
  logic rst_s1, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  mode_t            mode;
  logic [PRE_W-1:0] pre_n;
  logic             pin_en, cur_ext, pending, div_tick, ext_t, want_ext;

  slowclk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cur_ext(cur_ext), .rdata(reg_rdata),
    .mode(mode), .pre_n(pre_n), .pin_en(pin_en)
  );

  slowclk_div #(.FIX_DIV(FIX_DIV), .PRE_W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .in_tick(int_osc_tick),
    .pre_n(pre_n), .out_tick(div_tick)
  );

  assign ext_t    = ext_osc_tick && mode.xtal_en;
  assign want_ext = mode.src_req && !(ext_fail && !mode.bypass);

  slowclk_switch #(.SETTLE(SETTLE)) u_sw (
    .clk(clk), .rst_n(rst_sync_n), .want_ext(want_ext),
    .int_t(div_tick), .ext_t(ext_t), .cur_ext(cur_ext),
    .pending(pending), .tick(slow_tick)
  );

  assign ext_osc_en = mode.xtal_en;
  assign pin_tick   = slow_tick && pin_en;
endmodule

// File: rtl/slowclk_sel_chk.sv
module slowclk_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic [15:0] reg_key,
  input logic        src_req,
  input logic        xtal_en,
  input logic        bypass,
  input logic        cur_ext,
  input logic        pending,
  input logic        slow_tick,
  input logic        pin_tick,
  input logic        pin_en,
  input logic        div_tick,
  input logic        int_osc_tick
);
  // R2: a mode write carrying a wrong key leaves the mode bits untouched
  a_r2_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'h00 && reg_key != 16'h16AA)
      |=> ($stable(src_req) && $stable(xtal_en) && $stable(bypass)));

  // R5: no tick leaves the block while a source change is pending
  a_r5_mute_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> !slow_tick);

  // R5: the current source only moves at the end of a pending handshake
  a_r5_commit_after_pend: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_ext) |-> $past(pending));

  // R6: with the crystal disabled, the external path emits nothing
  a_r6_xtal_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ext && !xtal_en && !pending) |=> !slow_tick);

  // R8: the pin tick needs both the slow tick and the gate
  a_r8_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pin_tick |-> (slow_tick && pin_en));

  // R3: a divided tick follows an internal input pulse
  a_r3_div_from_input: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> $past(int_osc_tick));
endmodule

bind slowclk_sel slowclk_sel_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_key(reg_wdata[31:16]), .src_req(mode.src_req), .xtal_en(mode.xtal_en),
  .bypass(mode.bypass), .cur_ext(cur_ext), .pending(pending),
  .slow_tick(slow_tick), .pin_tick(pin_tick), .pin_en(pin_en),
  .div_tick(div_tick), .int_osc_tick(int_osc_tick)
);

// File: tb/slowclk_sel_tb.sv
module slowclk_sel_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr, int_osc_tick, ext_osc_tick, ext_fail;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        ext_osc_en, slow_tick, pin_tick;

  int errors = 0, checks = 0, n_slow = 0, n_pin = 0;

  slowclk_sel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_osc_tick(int_osc_tick), .ext_osc_tick(ext_osc_tick),
    .ext_fail(ext_fail), .ext_osc_en(ext_osc_en),
    .slow_tick(slow_tick), .pin_tick(pin_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (slow_tick) n_slow++;
    if (pin_tick)  n_pin++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    int_osc_tick = 1'b0; ext_osc_tick = 1'b0; ext_fail = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_slow = 0; n_pin = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pulse_int(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) int_osc_tick = 1'b1;
      @(negedge clk) int_osc_tick = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_osc_tick = 1'b1;
      @(negedge clk) ext_osc_tick = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd(8'h00, v); check("R1 mode reset", v, 0);
    rd(8'h08, v); check("R1 div reset", v, 0);
    rd(8'h60, v); check("R1 pin reset", v, 0);
    check("R1 xtal enable low", ext_osc_en, 0);
    pulse_ext(3);
    check("R1 no tick from idle crystal", n_slow, 0);
  endtask

  task automatic t_key();
    int v;
    do_reset();
    wr(8'h00, 32'h1234_8011);
    rd(8'h00, v); check("R2 wrong key ignored", v, 0);
    check("R2 wrong key xtal stays off", ext_osc_en, 0);
    wr(8'h00, 32'h16AA_8010);
    rd(8'h00, v); check("R9 mode readback bits 15,4", v, 32'h8010);
    wr(8'h00, 32'h16AB_0000);
    rd(8'h00, v); check("R2 near key ignored", v, 32'h8010);
    wr(8'h08, 32'hFFFF_FFF5);
    rd(8'h08, v); check("R9 div readback", v, 32'h15);
  endtask

  task automatic t_divide();
    do_reset();
    pulse_int(64);
    check("R3 N=0 64 pulses", n_slow, 2);
    do_reset();
    wr(8'h08, 32'd2);
    pulse_int(95);
    check("R3 N=2 95 pulses", n_slow, 0);
    pulse_int(97);
    check("R3 N=2 192 pulses", n_slow, 2);
    do_reset();
    wr(8'h08, 32'd31);
    pulse_int(1023);
    check("R3 N=31 1023 pulses", n_slow, 0);
    pulse_int(1);
    check("R3 N=31 1024 pulses", n_slow, 1);
  endtask

  task automatic t_switch();
    int v;
    do_reset();
    wr(8'h00, 32'h16AA_0011);
    check("R9 xtal enable out", ext_osc_en, 1);
    pulse_ext(1);
    pulse_int(64);
    rd(8'h00, v); check("R5 one new tick: still internal", v & 1, 0);
    check("R5 muted while pending", n_slow, 0);
    pulse_ext(1);
    rd(8'h00, v); check("R5 second tick commits", v & 1, 1);
    check("R5 switching ticks not emitted", n_slow, 0);
    pulse_ext(5);
    check("R4 external ticks pass", n_slow, 5);
  endtask

  task automatic t_xtal_off();
    int v;
    do_reset();
    wr(8'h00, 32'h16AA_0001);
    pulse_ext(4);
    rd(8'h00, v); check("R6 crystal off keeps internal", v & 1, 0);
    check("R6 no ticks", n_slow, 0);
  endtask

  task automatic t_fallback();
    int v;
    do_reset();
    wr(8'h00, 32'h16AA_0011);
    pulse_ext(2);
    @(negedge clk) ext_fail = 1'b1;
    pulse_int(64);
    rd(8'h00, v); check("R7 fallback to internal", v & 1, 0);
    check("R7 fallback muted", n_slow, 0);
    pulse_int(32);
    check("R7 internal after fallback", n_slow, 1);
    do_reset();
    wr(8'h00, 32'h16AA_8011);
    pulse_ext(2);
    @(negedge clk) ext_fail = 1'b1;
    pulse_int(64);
    rd(8'h00, v); check("R7 bypass keeps external", v & 1, 1);
    pulse_ext(3);
    check("R7 bypass ticks pass", n_slow, 3);
  endtask

  task automatic t_pin();
    int v;
    do_reset();
    pulse_int(64);
    check("R8 gate off pin silent", n_pin, 0);
    wr(8'h60, 32'h1);
    rd(8'h60, v); check("R9 pin readback", v, 1);
    pulse_int(64);
    check("R8 gate on pin follows", n_pin, 2);
    check("R8 slow count total", n_slow, 4);
  endtask

  initial begin
    t_reset();
    t_key();
    t_divide();
    t_switch();
    t_xtal_off();
    t_fallback();
    t_pin();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule